// File: doc/BRIEF.md
# PASID Allocation Command Engine

This block hands out and takes back process address space identifiers (PASIDs) from a pool held as a bitmap, and it is driven entirely through a small register window. Software writes a 64-bit command word. The engine raises a busy flag in the response word and keeps it up for a fixed number of cycles. It then drops the flag and posts a coded status. When the command was an allocation and it succeeded, the response also carries the granted identifier.

Software reads the capability word to learn that allocation is offered. It issues one command, polls the response until the busy flag reads zero, and then decodes the status. The register port has no back-pressure. A command write that lands while the engine is busy is dropped without any sign, so software must wait for the busy flag to clear before it writes again. Identifier 0 is never handed out. Allocation always grants the lowest free identifier.

Register window: address 0 is the capability word (read-only), address 1 is the command word (it reads back the last accepted command), and address 2 is the response word (read-only). Writes to addresses 0 and 2 have no effect.

Top module: `pasid_cmd_engine`

## Requirements
- R1: A read of address 0 returns 64'h1: bit 0 advertises allocation support and every other bit is zero.
- R2: An accepted command write sets response bit 0 from the next cycle on. The bit stays set for exactly LATENCY cycles and then reads 0, with the status and result already posted in that same word.
- R3: Opcode 8'h01 in command bits [7:0] allocates. It returns status 0 in response bits [2:1] and the lowest free identifier, never 0, in response bits [27:8], and it marks that identifier used.
- R4: An allocation when every identifier from 1 to POOL_DEPTH-1 is in use returns status 1 with a result field of 0, and the pool is left unchanged.
- R5: Opcode 8'h02 frees the identifier held in command bits [27:8]. When that identifier is allocated, the response is status 0 with a zero result field, and the identifier becomes available again.
- R6: A free of identifier 0, of an identifier at or above POOL_DEPTH, or of one that is not allocated returns status 1 and leaves the pool unchanged.
- R7: Any other opcode completes with status 2 and leaves the pool unchanged.
- R8: A command write that arrives while response bit 0 is set is ignored. It changes neither the command readback, the pool nor the posted result.
- R9: Reset clears the response word to zero, clears the command readback and empties the pool, so the next allocation returns identifier 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_waddr | input | 2 | Write address (1 = command) |
| reg_wdata | input | 64 | Write data |
| reg_raddr | input | 2 | Read address (0 cap, 1 command, 2 response) |
| reg_rdata | output | 64 | Read data, combinational from reg_raddr |

## Verification
The hardest states to reach are a completely full pool and a second command write arriving inside the busy window. A directed run of POOL_DEPTH-1 allocations reaches the full pool, and the next allocation is then expected to fail. The bench also issues a second write one cycle after an accepted command, which catches the engine while it is busy. After that, seeded random mixes of allocations, frees of valid, stale and out-of-range identifiers, and stray opcodes drive the pool through many partly-filled layouts. A bench-side bitmap model checks every one of these commands.

// File: rtl/pasid_eng_pkg.sv
package pasid_eng_pkg;
  localparam int WORD_W   = 64;
  localparam int OPC_W    = 8;
  localparam int ID_W     = 20;
  localparam int ID_LSB   = 8;

  localparam logic [OPC_W-1:0] OPC_ALLOC = 8'h01;
  localparam logic [OPC_W-1:0] OPC_FREE  = 8'h02;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_NONE  = 2'd1,
    ST_BADOP = 2'd2
  } status_e;

  typedef enum logic [1:0] {
    A_CAP = 2'd0,
    A_CMD = 2'd1,
    A_RSP = 2'd2
  } regaddr_e;
endpackage

// File: rtl/pasid_pool.sv
module pasid_pool #(
  parameter int DEPTH = 64,
  parameter int ID_W  = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            do_alloc,
  input  logic            do_free,
  input  logic [ID_W-1:0] free_id,
  output logic            alloc_ok,
  output logic [ID_W-1:0] alloc_id,
  output logic            free_ok
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [ID_W-1:0] DEPTH_ID = ID_W'(DEPTH);

  logic [DEPTH-1:0] used;
  logic [IDX_W-1:0] low_idx;
  logic             low_found;
  logic [IDX_W-1:0] free_idx;

  // lowest clear bit at index 1 or above; index 0 is reserved
  always_comb begin
    low_found = 1'b0;
    low_idx   = '0;
    for (int i = DEPTH - 1; i >= 1; i--) begin
      if (!used[i]) begin
        low_found = 1'b1;
        low_idx   = IDX_W'(i);
      end
    end
  end

  assign alloc_ok = low_found;
  assign alloc_id = ID_W'(low_idx);
  assign free_idx = free_id[IDX_W-1:0];
  assign free_ok  = (free_id != '0) && (free_id < DEPTH_ID) && used[free_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
    end else begin
      if (do_alloc && low_found) used[low_idx] <= 1'b1;
      if (do_free && free_ok)    used[free_idx] <= 1'b0;
    end
  end

  // R3
  alloc_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && alloc_ok && !do_free) |=> ($countones(used) == $past($countones(used)) + 1));

  // R4
  full_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && !alloc_ok) |-> (&used[DEPTH-1:1]));

  // R6
  bad_free_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_free && !free_ok && !do_alloc) |=> $stable(used));

  // R3
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (used[0] == 1'b0));
endmodule

// File: rtl/pasid_cmd_seq.sv
module pasid_cmd_seq #(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATENCY - 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_LAST;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= CNT_LAST));

  // R2
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/pasid_cmd_engine.sv
module pasid_cmd_engine
  import pasid_eng_pkg::*;
#(
  parameter int POOL_DEPTH = 64,
  parameter int LATENCY    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_waddr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [1:0]        reg_raddr,
  output logic [WORD_W-1:0] reg_rdata
);
  localparam int PAD_W = WORD_W - ID_W - ID_LSB;

  logic [WORD_W-1:0] cmd_q;
  logic [WORD_W-1:0] rsp_q;
  logic              busy;
  logic              done;
  logic              accept;
  logic [OPC_W-1:0]  opc;
  logic              is_alloc;
  logic              is_free;
  logic              alloc_ok;
  logic              free_ok;
  logic [ID_W-1:0]   alloc_id;
  status_e           stat;
  logic [ID_W-1:0]   res_id;

  assign accept   = reg_wr && (reg_waddr == A_CMD) && !busy;
  assign opc      = cmd_q[OPC_W-1:0];
  assign is_alloc = (opc == OPC_ALLOC);
  assign is_free  = (opc == OPC_FREE);

  pasid_cmd_seq #(.LATENCY(LATENCY)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy),
    .done  (done)
  );

  pasid_pool #(.DEPTH(POOL_DEPTH), .ID_W(ID_W)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .do_alloc (done && is_alloc),
    .do_free  (done && is_free),
    .free_id  (cmd_q[ID_LSB +: ID_W]),
    .alloc_ok (alloc_ok),
    .alloc_id (alloc_id),
    .free_ok  (free_ok)
  );

  always_comb begin
    stat   = ST_BADOP;
    res_id = '0;
    if (is_alloc) begin
      stat   = alloc_ok ? ST_OK : ST_NONE;
      res_id = alloc_ok ? alloc_id : '0;
    end else if (is_free) begin
      stat = free_ok ? ST_OK : ST_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      rsp_q <= '0;
    end else if (accept) begin
      cmd_q <= reg_wdata;
      rsp_q <= WORD_W'(1);
    end else if (done) begin
      rsp_q <= {{PAD_W{1'b0}}, res_id, 5'b0, stat, 1'b0};
    end
  end

  always_comb begin
    case (reg_raddr)
      A_CAP:   reg_rdata = WORD_W'(1);
      A_CMD:   reg_rdata = cmd_q;
      A_RSP:   reg_rdata = rsp_q;
      default: reg_rdata = '0;
    endcase
  end

  // R2
  rsp_busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_q[0] == busy));

  // R8
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> $stable(cmd_q));

  // R7
  badop_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_alloc && !is_free) |=> (rsp_q[2:1] == 2'd2));

  // R3
  alloc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_alloc && alloc_ok) |=> (rsp_q[ID_LSB +: ID_W] != '0));
endmodule

// File: tb/sim_pasid_cmd_engine.sv
module sim_pasid_cmd_engine;
  localparam int D   = 32;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_waddr = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = 2'd0;
  logic [63:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit mdl [D];

  always #2 clk = ~clk;

  pasid_cmd_engine #(.POOL_DEPTH(D), .LATENCY(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] predict(input logic [63:0] w);
    logic [19:0] id;
    case (w[7:0])
      8'h01: begin
        for (int i = 1; i < D; i++) begin
          if (!mdl[i]) begin
            mdl[i] = 1'b1;
            return (64'(i) << 8);
          end
        end
        return 64'h2;
      end
      8'h02: begin
        id = w[27:8];
        if (id != 0 && id < D && mdl[id[4:0]]) begin
          mdl[id[4:0]] = 1'b0;
          return 64'h0;
        end
        return 64'h2;
      end
      default: return 64'h4;
    endcase
  endfunction

  task automatic read_reg(input logic [1:0] a, output logic [63:0] v);
    reg_raddr = a;
    #1 v = reg_rdata;
  endtask

  // issue cmd, optionally a second write one cycle later; returns response and busy length
  task automatic run_cmd(input logic [63:0] w, input bit extra, input logic [63:0] w2,
                         output logic [63:0] rsp, output int blen);
    logic [63:0] v;
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = 2'd1; reg_wdata = w;
    @(negedge clk);
    if (extra) reg_wdata = w2;
    else reg_wr = 1'b0;
    blen = 0;
    read_reg(2'd2, v);
    while (v[0] && blen < 50) begin
      blen++;
      @(negedge clk);
      reg_wr = 1'b0;
      read_reg(2'd2, v);
    end
    reg_wr = 1'b0;
    rsp = v;
  endtask

  task automatic op(input string req, input logic [63:0] w);
    logic [63:0] rsp, exp;
    int blen;
    exp = predict(w);
    run_cmd(w, 1'b0, '0, rsp, blen);
    check("R2", 64'(blen), 64'(LAT));
    check(req, rsp, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < D; i++) mdl[i] = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v, rsp, exp;
    int blen;
    void'($urandom(32'd4242));
    for (int i = 0; i < D; i++) mdl[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state, R1 capability
    read_reg(2'd2, v); check("R9", v, 64'h0);
    read_reg(2'd1, v); check("R9", v, 64'h0);
    read_reg(2'd0, v); check("R1", v, 64'h1);

    // R3 first allocation gets 1, upper command bits ignored
    op("R3", 64'hABCD_0000_0000_0001);
    // R3 then fill to full, R4 on overflow
    for (int i = 2; i < D; i++) op("R3", 64'h1);
    op("R4", 64'h1);
    op("R4", 64'h1);
    // R5 free and realloc
    op("R5", (64'd5 << 8) | 64'h2);
    op("R5", 64'h1);
    op("R5", (64'd9 << 8) | 64'h2);
    op("R5", (64'd5 << 8) | 64'h2);
    op("R3", 64'h1);
    // R6 bad frees
    op("R6", (64'd9 << 8) | 64'h2);
    op("R6", 64'h2);
    op("R6", (64'(D) << 8) | 64'h2);
    op("R6", (64'hFFFFF << 8) | 64'h2);
    op("R6", 64'h1);
    // R7 bad opcodes
    op("R7", 64'h7F);
    op("R7", 64'h0);
    op("R7", (64'd1 << 8) | 64'h3);
    op("R7", 64'h1);

    // R8 write during busy is dropped
    op("R8", (64'd3 << 8) | 64'h2);
    exp = predict(64'h1);
    run_cmd(64'h1, 1'b1, (64'd4 << 8) | 64'h2, rsp, blen);
    check("R8", rsp, exp);
    read_reg(2'd1, v); check("R8", v, 64'h1);
    op("R8", (64'd4 << 8) | 64'h2);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [63:0] w;
      k = $urandom_range(0, 9);
      if (k < 4) w = ({32'($urandom), 32'($urandom)} & 64'hFFFF_FFFF_FFFF_FF00) | 64'h1;
      else if (k < 9) w = (64'($urandom_range(0, D + 3)) << 8) | 64'h2;
      else w = 64'($urandom_range(3, 255));
      op("R3", w);
    end

    // R9 reset mid-use
    do_reset();
    read_reg(2'd2, v); check("R9", v, 64'h0);
    read_reg(2'd1, v); check("R9", v, 64'h0);
    op("R9", 64'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule